// File: doc/BRIEF.md
# Saturating Hit and Miss Event Monitors

This block keeps two event tallies for a cache lookup stage: one counts lookups that hit, the other counts lookups that miss. The lookup stage drives a one-cycle strobe for each outcome. A control word holds a separate enable bit and a separate clear-request bit for each tally, so software can run, freeze or zero either one without touching the other.

Each tally is saturating. Once it reaches the all-ones value it stays there and does not roll over. Dropping an enable freezes that tally at its current value. A register read port returns either tally: the caller presents a select and gets registered data on the next cycle.

Top module: `cache_event_monitor`

## Requirements
- R1: After synchronous reset, both tallies read as zero.
- R2: While its enable is high, a tally increments by exactly one in each cycle in which its event strobe is high. The hit enable is control bit 0 and the miss enable is control bit 1.
- R3: When a tally reaches all ones it stays there on further enabled events and never wraps to zero.
- R4: While its enable is low, a tally keeps its value whatever the strobe does, and clearing the enable does not change the stored value.
- R5: Each clear-request bit sits two positions above the enable it belongs to: bit 2 clears the hit tally and bit 3 clears the miss tally. While a clear request is high, its tally is held at zero, even when an enabled event arrives in the same cycle.
- R6: The two tallies are independent. Enabling, clearing or strobing one never changes the other, so counting can run for hits only, for misses only, or for both.
- R7: Read select 0 returns the hit tally and read select 1 returns the miss tally. The data is valid one cycle after a read request and holds its value until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 4 | Bit 0: hit enable. Bit 1: miss enable. Bit 2: hit clear request. Bit 3: miss clear request. |
| hit_evt | input | 1 | One-cycle strobe for a cache hit |
| miss_evt | input | 1 | One-cycle strobe for a cache miss |
| rd_req | input | 1 | Read request |
| rd_sel | input | 1 | Read select: 0 for the hit tally, 1 for the miss tally |
| rd_data | output | 32 | Registered read data |

## Verification
The assertions assume that the hit and miss strobes are never high in the same cycle, as a real lookup stage guarantees, and one assertion checks this at the inputs. The bench drives the strobes from tasks that raise at most one of them per cycle. The saturation checks assume the tally can reach all ones, which 2^32 events would make impossible in a run. The bench therefore builds a copy with a narrow counter parameter, where the limit is reachable, while the 32-bit copy covers the normal function.

// File: rtl/cache_event_monitor_pkg.sv
package cache_event_monitor_pkg;
  localparam int unsigned NUM_MON = 2;
  localparam int unsigned MON_HIT = 0;
  localparam int unsigned MON_MISS = 1;
  localparam int unsigned CLR_OFFSET = 2;
  localparam int unsigned CTRL_W = NUM_MON + CLR_OFFSET;
endpackage

// File: rtl/sat_event_counter.sv
module sat_event_counter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             evt,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (en && evt && (count != MAXV)) begin
      count <= count + 1'b1;
    end
  end

  p_clear_wins_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (count == MAXV && !clr) |=> (count == MAXV));
  p_hold_when_off_r4: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(count));
  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    (en && evt && !clr && count != MAXV) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/monitor_read_port.sv
module monitor_read_port #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  logic             rd_sel,
  input  logic [WIDTH-1:0] hit_val,
  input  logic [WIDTH-1:0] miss_val,
  output logic [WIDTH-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_req) begin
      rd_data <= rd_sel ? miss_val : hit_val;
    end
  end

  p_read_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(rd_data));
endmodule

// File: rtl/cache_event_monitor.sv
module cache_event_monitor
  import cache_event_monitor_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              hit_evt,
  input  logic              miss_evt,
  input  logic              rd_req,
  input  logic              rd_sel,
  output logic [CNT_W-1:0]  rd_data
);
  logic [NUM_MON-1:0] evt_vec;
  logic [CNT_W-1:0]   cnt [NUM_MON];

  assign evt_vec[MON_HIT]  = hit_evt;
  assign evt_vec[MON_MISS] = miss_evt;

  for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
    sat_event_counter #(.WIDTH(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .en    (ctrl[g]),
      .clr   (ctrl[g+CLR_OFFSET]),
      .evt   (evt_vec[g]),
      .count (cnt[g])
    );
  end

  monitor_read_port #(.WIDTH(CNT_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (rd_req),
    .rd_sel   (rd_sel),
    .hit_val  (cnt[MON_HIT]),
    .miss_val (cnt[MON_MISS]),
    .rd_data  (rd_data)
  );

  p_excl_strobes_r6: assert property (@(posedge clk) disable iff (rst)
    !(hit_evt && miss_evt));
  p_miss_isolated_r6: assert property (@(posedge clk) disable iff (rst)
    (!miss_evt && !ctrl[MON_MISS+CLR_OFFSET]) |=> $stable(cnt[MON_MISS]));
endmodule

// File: tb/cache_event_monitor_tb.sv
module cache_event_monitor_tb;
  localparam int W = 32;
  localparam int NW = 4;

  logic clk = 0;
  logic rst = 1;
  logic [3:0] ctrl = 0;
  logic hit_evt = 0, miss_evt = 0, rd_req = 0, rd_sel = 0;
  logic [W-1:0] rd_data;
  logic [3:0] nctrl = 0;
  logic nhit = 0, nreq = 0;
  logic [NW-1:0] nrd;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  cache_event_monitor #(.CNT_W(W)) u_dut (.clk(clk), .rst(rst), .ctrl(ctrl),
    .hit_evt(hit_evt), .miss_evt(miss_evt), .rd_req(rd_req), .rd_sel(rd_sel),
    .rd_data(rd_data));
  cache_event_monitor #(.CNT_W(NW)) u_narrow (.clk(clk), .rst(rst), .ctrl(nctrl),
    .hit_evt(nhit), .miss_evt(1'b0), .rd_req(nreq), .rd_sel(1'b0),
    .rd_data(nrd));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic read(input logic sel, output logic [W-1:0] v);
    rd_req = 1; rd_sel = sel;
    tick();
    rd_req = 0;
    v = rd_data;
  endtask

  task automatic pulses(input logic h, input int n);
    for (int i = 0; i < n; i++) begin
      hit_evt = h; miss_evt = !h;
      tick();
    end
    hit_evt = 0; miss_evt = 0;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    read(0, v); chk("R1 hit", v, 0);
    read(1, v); chk("R1 miss", v, 0);
  endtask

  task automatic t_count;
    logic [W-1:0] v;
    ctrl = 4'b0011;
    pulses(1, 5); pulses(0, 3);
    tick(2);
    read(0, v); chk("R2 hit", v, 5);
    read(1, v); chk("R2 miss", v, 3);
  endtask

  task automatic t_freeze;
    logic [W-1:0] v;
    ctrl = 4'b0010;
    pulses(1, 4);
    read(0, v); chk("R4 hit frozen", v, 5);
    pulses(0, 2);
    read(1, v); chk("R6 miss only", v, 5);
    ctrl = 4'b0000;
    pulses(0, 3);
    read(1, v); chk("R4 miss frozen", v, 5);
    read(0, v); chk("R4 hit kept", v, 5);
  endtask

  task automatic t_clear;
    logic [W-1:0] v;
    ctrl = 4'b0111;
    pulses(1, 3);
    ctrl = 4'b0011;
    tick();
    read(0, v); chk("R5 hit cleared", v, 0);
    read(1, v); chk("R6 miss kept", v, 5);
    pulses(1, 2);
    read(0, v); chk("R2 recount", v, 2);
    ctrl = 4'b1011;
    tick(); ctrl = 4'b0011; tick();
    read(1, v); chk("R5 miss cleared", v, 0);
    read(0, v); chk("R6 hit kept", v, 2);
  endtask

  task automatic t_read_hold;
    logic [W-1:0] v;
    read(0, v);
    ctrl = 4'b0001;
    pulses(1, 3);
    chk("R7 hold", rd_data, 2);
    read(0, v); chk("R7 fresh", v, 5);
  endtask

  task automatic t_sat;
    nctrl = 4'b0001;
    for (int i = 0; i < 20; i++) begin nhit = 1; tick(); end
    nhit = 0;
    nreq = 1; tick(); nreq = 0;
    chk("R3 saturate", {28'd0, nrd}, 15);
    nhit = 1; tick(3); nhit = 0;
    nreq = 1; tick(); nreq = 0;
    chk("R3 no wrap", {28'd0, nrd}, 15);
  endtask

  initial begin
    fork
      begin
        tick(3); rst = 0; tick();
        t_reset(); t_count(); t_freeze(); t_clear(); t_read_hold(); t_sat();
      end
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule